// File: doc/BRIEF.md
# Inter-Processor Channel Mailbox

This block passes 32-bit messages between a host CPU and a coprocessor, one queue for each direction. Each message word carries a 28-bit payload in bits 31:4 and a 4-bit channel tag in bits 3:0. The block moves both fields through unchanged, so host software can check that a reply came back on the channel it expects. The host reaches the block through a simple register bus slave with three registers:

- **Inbox**: reading it removes one word from the coprocessor-to-host queue.
- **Flags**: reports whether the host-to-coprocessor queue is full and whether the coprocessor-to-host queue is empty. It also holds two sticky error bits.
- **Outbox**: writing it appends one word to the host-to-coprocessor queue.

On the coprocessor side there are two plain valid/ready ports: one delivers outbound words and one accepts inbound words. Each queue is an 8-entry FIFO. Software must poll the flags before each access. An access made against a flag is handled safely: a write to a full outbox is dropped and a read of an empty inbox repeats the previous word. Either case is latched in a sticky bit, and a read of the flags register clears both sticky bits.

The bus responder is a two-state machine:

- **BUS_IDLE** stays in BUS_IDLE when there is no read request.
- **BUS_IDLE** moves to BUS_RESP when a read request is accepted.
- **BUS_RESP** stays in BUS_RESP when another read arrives back-to-back.
- **BUS_RESP** returns to BUS_IDLE otherwise.

Writes take effect at the request edge and never leave BUS_IDLE.

Top module: `chan_mailbox`

## Requirements
- R1: A word written to the outbox leaves on the coprocessor output port with all 32 bits intact, and a word taken in on the coprocessor input port is returned by an inbox read with all 32 bits intact. Bits 31:4 are the payload and bits 3:0 are the channel tag, and neither field is altered.
- R2: Register offsets on the 6-bit bus address are fixed:
  - inbox at 0x00, reads only;
  - flags at 0x18, reads only;
  - outbox at 0x20, writes only.
  A read of any other offset returns zero. A write to any offset other than 0x20 changes no state.
- R3: Flags bit 31 is 1 exactly when 8 words are waiting in the host-to-coprocessor queue.
- R4: Flags bit 30 is 1 exactly when the coprocessor-to-host queue holds no word.
- R5: A read request raises bus_rvalid for the cycle after the request edge, and bus_rdata carries the result in that cycle. Inbox reads return queued words oldest first, one word removed per read.
- R6: An inbox read while the inbox is empty returns the last word previously removed (zero after reset) and sets sticky underflow flags bit 1.
- R7: An outbox write while the outbox is full is discarded and sets sticky overflow flags bit 0.
- R8: A flags read returns the sticky bits as they stand and clears both of them.
- R9: The coprocessor port handshakes behave as follows:
  - cp_in_ready is low while the inbox holds 8 words, and a word offered then is not taken.
  - cp_out_valid is high whenever the outbox is non-empty.
  - cp_out_data stays steady until cp_out_ready accepts it.
- R10: After reset both queues are empty, both sticky bits are zero, bus_rvalid is low, bus_rdata is zero, cp_out_valid is low and cp_in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| cp_out_valid | output | 1 | Outbound word available |
| cp_out_ready | input | 1 | Coprocessor takes the outbound word |
| cp_out_data | output | 32 | Outbound word (payload 31:4, channel 3:0) |
| cp_in_valid | input | 1 | Coprocessor offers an inbound word |
| cp_in_ready | output | 1 | Inbox can take a word |
| cp_in_data | input | 32 | Inbound word (payload 31:4, channel 3:0) |

## Verification
A read response, including any queue pop and sticky-bit update, is due one clock edge after the edge that samples the request. Flags reflect queue occupancy as it stood at that request edge. A coprocessor push or pop therefore shows in the flags only for requests issued after the edge that performed it. The bench drives every request on a falling edge and samples bus_rdata and bus_rvalid on the next falling edge, exactly one rising edge later. The coprocessor handshakes are stepped one falling edge per transfer, and the port outputs are checked before each step.

// File: rtl/chan_mailbox_pkg.sv
package chan_mailbox_pkg;

    localparam int WORD_W  = 32;
    localparam int CHAN_W  = 4;
    localparam int ADDR_W  = 6;

    // register offsets on the host bus
    localparam logic [ADDR_W-1:0] OFS_INBOX  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_FLAGS  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_OUTBOX = 6'h20;

    // bit positions inside the flags register
    localparam int FLG_OUT_FULL  = 31;
    localparam int FLG_IN_EMPTY  = 30;
    localparam int FLG_UNDERFLOW = 1;
    localparam int FLG_OVERFLOW  = 0;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/chan_mailbox_fifo.sv
module chan_mailbox_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_MAX);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // occupancy never exceeds the queue depth
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);

    // a push into a full queue without a pop leaves the occupancy unchanged
    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

endmodule

// File: rtl/chan_mailbox_regs.sv
module chan_mailbox_regs
    import chan_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              out_push,
    output logic [WORD_W-1:0] out_din,
    input  logic              out_full,
    output logic              in_pop,
    input  logic [WORD_W-1:0] in_dout,
    input  logic              in_empty
);
    bus_state_e        state_q, state_d;
    logic              acc_rd, acc_wr;
    logic              hit_inbox, hit_flags, hit_outbox;
    logic [WORD_W-1:0] flags_word, rd_mux;
    logic [WORD_W-1:0] rdata_q, last_q;
    logic              ovf_q, unf_q;

    assign acc_rd     = bus_sel && !bus_we;
    assign acc_wr     = bus_sel && bus_we;
    assign hit_inbox  = acc_rd && (bus_addr == OFS_INBOX);
    assign hit_flags  = acc_rd && (bus_addr == OFS_FLAGS);
    assign hit_outbox = acc_wr && (bus_addr == OFS_OUTBOX);

    assign in_pop   = hit_inbox;
    assign out_push = hit_outbox;
    assign out_din  = bus_wdata;

    always_comb begin
        flags_word                = '0;
        flags_word[FLG_OUT_FULL]  = out_full;
        flags_word[FLG_IN_EMPTY]  = in_empty;
        flags_word[FLG_UNDERFLOW] = unf_q;
        flags_word[FLG_OVERFLOW]  = ovf_q;
    end

    always_comb begin
        if (hit_inbox) begin
            rd_mux = in_empty ? last_q : in_dout;
        end else if (hit_flags) begin
            rd_mux = flags_word;
        end else begin
            rd_mux = '0;
        end
    end

    // next-state logic of the bus responder
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = acc_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = acc_rd ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // data path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            last_q  <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            if (acc_rd) begin
                rdata_q <= rd_mux;
            end
            if (hit_inbox && !in_empty) begin
                last_q <= in_dout;
            end
            if (hit_flags) begin
                ovf_q <= 1'b0;
                unf_q <= 1'b0;
            end else begin
                if (hit_outbox && out_full) begin
                    ovf_q <= 1'b1;
                end
                if (hit_inbox && in_empty) begin
                    unf_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

    assert_rvalid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);

    assert_rvalid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> !bus_rvalid);

    assert_empty_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == OFS_INBOX && in_empty)
        |=> (bus_rdata == $past(last_q)) && unf_q);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == OFS_OUTBOX && out_full) |=> ovf_q);

    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == OFS_FLAGS) |=> (!ovf_q && !unf_q));

endmodule

// File: rtl/chan_mailbox.sv
module chan_mailbox
    import chan_mailbox_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              cp_out_valid,
    input  logic              cp_out_ready,
    output logic [WORD_W-1:0] cp_out_data,
    input  logic              cp_in_valid,
    output logic              cp_in_ready,
    input  logic [WORD_W-1:0] cp_in_data
);
    logic              out_push, out_full, out_empty;
    logic [WORD_W-1:0] out_din;
    logic              in_pop, in_full, in_empty;
    logic [WORD_W-1:0] in_dout;

    chan_mailbox_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .out_push   (out_push),
        .out_din    (out_din),
        .out_full   (out_full),
        .in_pop     (in_pop),
        .in_dout    (in_dout),
        .in_empty   (in_empty)
    );

    // host to coprocessor
    chan_mailbox_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_outq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (out_push),
        .din   (out_din),
        .pop   (cp_out_ready),
        .dout  (cp_out_data),
        .full  (out_full),
        .empty (out_empty)
    );

    // coprocessor to host
    chan_mailbox_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_inq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cp_in_valid),
        .din   (cp_in_data),
        .pop   (in_pop),
        .dout  (in_dout),
        .full  (in_full),
        .empty (in_empty)
    );

    assign cp_out_valid = !out_empty;
    assign cp_in_ready  = !in_full;

    // a stalled outbound word stays offered and unchanged
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out_valid && !cp_out_ready) |=> (cp_out_valid && $stable(cp_out_data)));

endmodule

// File: tb/chan_mailbox_tb.sv
module chan_mailbox_tb;
    import chan_mailbox_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              bus_sel, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [WORD_W-1:0] bus_wdata, bus_rdata;
    logic              bus_rvalid;
    logic              cp_out_valid, cp_out_ready;
    logic [WORD_W-1:0] cp_out_data;
    logic              cp_in_valid, cp_in_ready;
    logic [WORD_W-1:0] cp_in_data;

    chan_mailbox u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .cp_out_valid (cp_out_valid),
        .cp_out_ready (cp_out_ready),
        .cp_out_data  (cp_out_data),
        .cp_in_valid  (cp_in_valid),
        .cp_in_ready  (cp_in_ready),
        .cp_in_data   (cp_in_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns the response one rising edge later
    task automatic bus_op(input logic wr, input logic [5:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic rv);
        bus_sel   = 1'b1;
        bus_we    = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
        rd = bus_rdata;
        rv = bus_rvalid;
    endtask

    function automatic logic [31:0] inw(input int k);
        return {28'h0A50000 + 28'(k), 4'(k + 8)};
    endfunction

    localparam logic [31:0] OUTW [8] = '{
        32'h1000_0010, 32'h1000_0021, 32'h1000_0032, 32'h1000_0043,
        32'h1000_0054, 32'h1000_0065, 32'h1000_0076, 32'h1000_0087
    };

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h18, 32'h0, 32'h4000_0000, 4'd4},   // R4 inbox empty after reset
        '{1'b0, 6'h04, 32'h0, 32'h0000_0000, 4'd2},   // R2 unmapped read
        '{1'b0, 6'h3C, 32'h0, 32'h0000_0000, 4'd2},   // R2 unmapped read
        '{1'b1, 6'h20, OUTW[0], 32'h0, 4'd1},         // R1 fill outbox
        '{1'b1, 6'h20, OUTW[1], 32'h0, 4'd1},
        '{1'b1, 6'h20, OUTW[2], 32'h0, 4'd1},
        '{1'b1, 6'h20, OUTW[3], 32'h0, 4'd1},
        '{1'b1, 6'h20, OUTW[4], 32'h0, 4'd1},
        '{1'b1, 6'h20, OUTW[5], 32'h0, 4'd1},
        '{1'b1, 6'h20, OUTW[6], 32'h0, 4'd1},
        '{1'b1, 6'h20, OUTW[7], 32'h0, 4'd1},
        '{1'b0, 6'h18, 32'h0, 32'hC000_0000, 4'd3},   // R3 outbox full
        '{1'b1, 6'h20, 32'hDEAD_BEEF, 32'h0, 4'd7},   // R7 write while full
        '{1'b0, 6'h18, 32'h0, 32'hC000_0001, 4'd7},   // R7 overflow sticky
        '{1'b0, 6'h18, 32'h0, 32'hC000_0000, 4'd8},   // R8 cleared by read
        '{1'b0, 6'h00, 32'h0, 32'h0000_0000, 4'd6},   // R6 empty read, zero
        '{1'b0, 6'h18, 32'h0, 32'hC000_0002, 4'd6},   // R6 underflow sticky
        '{1'b1, 6'h18, 32'hFFFF_FFFF, 32'h0, 4'd2},   // R2 write to flags ignored
        '{1'b1, 6'h00, 32'hFFFF_FFFF, 32'h0, 4'd2},   // R2 write to inbox ignored
        '{1'b0, 6'h18, 32'h0, 32'hC000_0000, 4'd2}    // R2 nothing changed
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        rv;
        rst_n = 1'b0;
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        cp_out_ready = 1'b0; cp_in_valid = 1'b0; cp_in_data = '0;
        repeat (3) @(negedge clk);
        chk("R10 rvalid", 32'(bus_rvalid), 32'd0);
        chk("R10 rdata", bus_rdata, 32'd0);
        chk("R10 out_valid", 32'(cp_out_valid), 32'd0);
        chk("R10 in_ready", 32'(cp_in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, rv);
            if (!VEC[i].wr) begin
                chk($sformatf("R%0d row%0d rvalid", VEC[i].req, i), 32'(rv), 32'd1);
                chk($sformatf("R%0d row%0d rdata", VEC[i].req, i), rd, VEC[i].exp);
            end else begin
                chk($sformatf("R%0d row%0d no rvalid on write", VEC[i].req, i), 32'(rv), 32'd0);
            end
        end

        // drain outbox through coprocessor port: R1, R9
        cp_out_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            chk("R9 out_valid", 32'(cp_out_valid), 32'd1);
            chk("R1 out word", cp_out_data, OUTW[k]);
            chk("R1 out channel", 32'(cp_out_data[3:0]), 32'(k));
            @(negedge clk);
        end
        chk("R7 dropped word absent", 32'(cp_out_valid), 32'd0);
        cp_out_ready = 1'b0;
        bus_op(1'b0, 6'h18, 32'h0, rd, rv);
        chk("R3 full cleared after drain", rd, 32'h4000_0000);

        // fill inbox from coprocessor: R9
        for (int k = 0; k < 8; k++) begin
            chk("R9 in_ready", 32'(cp_in_ready), 32'd1);
            cp_in_valid = 1'b1;
            cp_in_data  = inw(k);
            @(negedge clk);
        end
        cp_in_data = 32'hFFFF_FFF5;
        chk("R9 in_ready low when full", 32'(cp_in_ready), 32'd0);
        @(negedge clk);
        chk("R9 in_ready stays low", 32'(cp_in_ready), 32'd0);
        cp_in_valid = 1'b0;
        bus_op(1'b0, 6'h18, 32'h0, rd, rv);
        chk("R4 inbox not empty", rd, 32'h0000_0000);

        for (int k = 0; k < 8; k++) begin
            bus_op(1'b0, 6'h00, 32'h0, rd, rv);
            chk("R5 inbox order", rd, inw(k));
            chk("R1 in channel", 32'(rd[3:0]), 32'(k + 8));
        end
        bus_op(1'b0, 6'h18, 32'h0, rd, rv);
        chk("R9 refused word not queued", rd, 32'h4000_0000);
        bus_op(1'b0, 6'h00, 32'h0, rd, rv);
        chk("R6 repeat last word", rd, inw(7));
        bus_op(1'b0, 6'h18, 32'h0, rd, rv);
        chk("R6 underflow set", rd, 32'h4000_0002);
        bus_op(1'b0, 6'h18, 32'h0, rd, rv);
        chk("R8 underflow cleared", rd, 32'h4000_0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule